// File: doc/BRIEF.md
# Zoned External Memory Bus Controller

This controller turns single internal read and write requests into strobed transfers on an asynchronous external memory bus. The bus has a 19-bit address and 16-bit data. Each request names a zone number. Five zone numbers (0, 1, 2, 6 and 7) are mapped. Each mapped zone has its own active-low chip-select and its own timing word. Requests to any other zone number finish without touching the bus.

Every transfer runs through three phases: setup (lead), strobe (active) and hold (trail). Each phase is counted in timing-clock periods.

- Reads and writes in one zone use separate counts.
- A per-zone doubling bit multiplies all three counts by two.
- A per-zone ready enable lets the external ready input stretch the strobe phase.

The core clock `clk` runs at twice the system rate. The timing clock is one half or one quarter of `clk`, so one timing period lasts 2 or 4 `clk` cycles. A registered bus clock output runs at the timing rate or at half of it, or is held low.

On the internal side, a request is held until a one-cycle acknowledge. Read data is presented once the acknowledge has been given.

Top module: `ebus_ctrl`

## Requirements
- R1: Chip-select bits 0 to 4 of `bus_cs_n_o` belong to zones 0, 1, 2, 6 and 7 in that order. They are active low. At most one is low. During a mapped transfer only that zone's bit is low, and `bus_addr_o` holds the request address.
- R2: A request to zone 3, 4 or 5 asserts no chip-select and no strobe, and is still acknowledged.
- R3: Timing word layout:
  - Read fields: setup in bits 1:0, strobe in bits 4:2, hold in bits 6:5.
  - Write fields: setup in bits 8:7, strobe in bits 11:9, hold in bits 13:12.
  - Bit 14 is ready enable and bit 15 is doubling.
  - Reset value is 0x3FFF.
  - A strobe count of 0 acts as 1.
- R4: The chip-select is low for setup+strobe+hold timing periods. The strobe is low only during the strobe periods, and these start after the setup periods.
- R5: With the doubling bit set, all three counts of that zone are doubled, so a strobe count of 7 gives 14 periods.
- R6: On a read, `rdata_o` takes `bus_rdata_i` as sampled at the clock edge that ends the strobe phase.
- R7: On a write, `bus_data_oe_o` is high and `bus_wdata_o` holds the write data for the whole chip-select window. `bus_wr_n_o` is low only in the strobe phase. Reads never drive data, and the two strobes are never low together.
- R8: When the zone's ready enable is set, `bus_rdy_i` low at the final strobe tick extends the strobe by whole timing periods until ready is seen high. When ready enable is clear, ready has no effect.
- R9: `tim_half_i` = 0 gives a timing period of 2 `clk` cycles. `tim_half_i` = 1 gives 4 `clk` cycles.
- R10: `bus_clk_o` toggles every 1, 2 or 4 `clk` cycles, which is the timing half-period multiplied by 2 when `clkout_half_i` = 1. With `clkout_off_i` set it is held low.
- R11: `ack_o` is high for exactly one cycle. It starts in the cycle after the last hold cycle, and no further transfer is accepted while one is in progress.
- R12: A timing-word write during a transfer does not change that transfer. Writes naming an unmapped zone change no timing word.
- R13: During reset all chip-selects and strobes are high, and `bus_data_oe_o`, `ack_o`, `bus_clk_o` and `rdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the system rate |
| rst | input | 1 | Synchronous active-high reset |
| tim_half_i | input | 1 | Timing clock is half of the system rate |
| clkout_half_i | input | 1 | Bus clock is half of the timing rate |
| clkout_off_i | input | 1 | Hold bus clock low |
| cfg_we_i | input | 1 | Write a zone timing word |
| cfg_zone_i | input | 3 | Zone number for the timing write |
| cfg_word_i | input | 16 | Timing word |
| req_i | input | 1 | Transfer request, held until acknowledge |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_zone_i | input | 3 | Zone number of the request |
| req_addr_i | input | 19 | Request address |
| req_wdata_i | input | 16 | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Captured read data |
| bus_clk_o | output | 1 | External bus clock |
| bus_cs_n_o | output | 5 | Zone chip-selects, active low |
| bus_rd_n_o | output | 1 | Read strobe, active low |
| bus_wr_n_o | output | 1 | Write strobe, active low |
| bus_addr_o | output | 19 | Bus address |
| bus_wdata_o | output | 16 | Bus write data |
| bus_data_oe_o | output | 1 | Write data drive enable |
| bus_rdata_i | input | 16 | Bus read data |
| bus_rdy_i | input | 1 | External ready, low stretches the strobe |

## Verification
The assertions rely on three assumptions about the inputs:
- The request fields stay stable from the raising of `req_i` until the acknowledge.
- The clock-ratio inputs change only while no transfer is in progress.
- `req_i` is dropped before the controller returns to idle.

The stimulus keeps to these limits. It raises and lowers requests on falling edges and changes the clock modes only between transfers. It writes timing words either between transfers or, on purpose, in the middle of one, which is allowed. Ready is pulled low only from the start of a strobe and is released after a chosen number of strobe cycles, so the stretch the bench expects follows directly from the tick spacing.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  localparam int LEAD_W  = 2;
  localparam int ACT_W   = 3;
  localparam int TRAIL_W = 2;
  localparam int ZSEL_W  = 3;
  localparam int CNT_W   = ACT_W + 1;

  typedef struct packed {
    logic [TRAIL_W-1:0] trail;
    logic [ACT_W-1:0]   act;
    logic [LEAD_W-1:0]  lead;
  } phase_set_t;

  typedef struct packed {
    logic       dbl;
    logic       rdy_en;
    phase_set_t wr;
    phase_set_t rd;
  } zone_cfg_t;

  localparam int SET_W = $bits(phase_set_t);
  localparam int CFG_W = $bits(zone_cfg_t);
  localparam zone_cfg_t CFG_RESET = zone_cfg_t'({2'b00, {(2*SET_W){1'b1}}});

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_ACT,
    PH_TRAIL,
    PH_DONE
  } phase_t;
endpackage

// File: rtl/ebus_clkgen.sv
module ebus_clkgen #(
  parameter int REF_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tim_half_i,
  input  logic out_half_i,
  input  logic out_off_i,
  output logic tick_o,
  output logic clkout_o
);
  logic [REF_W-1:0] ref_q;
  logic             tog;

  always_ff @(posedge clk) begin
    if (rst) ref_q <= '0;
    else     ref_q <= ref_q + 1'b1;
  end

  // timing tick: every 2 clk, or every 4 clk in half mode
  assign tick_o = tim_half_i ? (ref_q == '1) : ref_q[0];

  always_comb begin
    if (tim_half_i) tog = out_half_i ? (ref_q == '1) : ref_q[0];
    else            tog = out_half_i ? ref_q[0] : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || out_off_i) clkout_o <= 1'b0;
    else if (tog)         clkout_o <= ~clkout_o;
  end
endmodule

// File: rtl/ebus_zone_regs.sv
module ebus_zone_regs import ebus_pkg::*; #(
  parameter int NZ = 5,
  parameter logic [NZ*ZSEL_W-1:0] ZMAP = {3'd7, 3'd6, 3'd2, 3'd1, 3'd0}
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we_i,
  input  logic [ZSEL_W-1:0]     cfg_zone_i,
  input  zone_cfg_t             cfg_word_i,
  output zone_cfg_t [NZ-1:0]    zcfg_o
);
  for (genvar k = 0; k < NZ; k++) begin : g_zone
    always_ff @(posedge clk) begin
      if (rst)
        zcfg_o[k] <= CFG_RESET;
      else if (cfg_we_i && (cfg_zone_i == ZMAP[k*ZSEL_W +: ZSEL_W]))
        zcfg_o[k] <= cfg_word_i;
    end
  end
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq import ebus_pkg::*; #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int NZ     = 5,
  parameter logic [NZ*ZSEL_W-1:0] ZMAP = {3'd7, 3'd6, 3'd2, 3'd1, 3'd0}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              req_wr_i,
  input  logic [ZSEL_W-1:0] req_zone_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  zone_cfg_t [NZ-1:0] zcfg_i,
  input  logic              rdy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NZ-1:0]     cs_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              data_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  phase_t           st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, act_q, act_n, trl_q, trl_n;
  logic [CNT_W-1:0] l_eff, a_eff, t_eff;
  logic [NZ-1:0]    hit_q, hit_n, hit_dec;
  logic             wr_q, wr_n, ren_q, ren_n, accept, cap, busy_n;
  zone_cfg_t        sel;
  phase_set_t       ts;

  always_comb begin
    sel = '0;
    for (int k = 0; k < NZ; k++) begin
      hit_dec[k] = (req_zone_i == ZMAP[k*ZSEL_W +: ZSEL_W]);
      if (hit_dec[k]) sel = zcfg_i[k];
    end
    ts    = req_wr_i ? sel.wr : sel.rd;
    l_eff = CNT_W'(ts.lead) << sel.dbl;
    a_eff = ((ts.act == '0) ? CNT_W'(1) : CNT_W'(ts.act)) << sel.dbl;
    t_eff = CNT_W'(ts.trail) << sel.dbl;
  end

  assign accept = (st_q == PH_IDLE) && tick_i && req_i;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    hit_n = hit_q;
    wr_n  = wr_q;
    act_n = act_q;
    trl_n = trl_q;
    ren_n = ren_q;
    cap   = 1'b0;
    case (st_q)
      PH_IDLE: if (accept) begin
        hit_n = hit_dec;
        wr_n  = req_wr_i;
        act_n = a_eff;
        trl_n = t_eff;
        ren_n = sel.rdy_en;
        if (hit_dec == '0)      st_n = PH_DONE;
        else if (l_eff != '0) begin st_n = PH_LEAD; cnt_n = l_eff; end
        else                  begin st_n = PH_ACT;  cnt_n = a_eff; end
      end
      PH_LEAD: if (tick_i) begin
        if (cnt_q == CNT_W'(1)) begin st_n = PH_ACT; cnt_n = act_q; end
        else cnt_n = cnt_q - 1'b1;
      end
      PH_ACT: if (tick_i) begin
        if (cnt_q == CNT_W'(1)) begin
          if (!(ren_q && !rdy_i)) begin
            cap = !wr_q;
            if (trl_q != '0) begin st_n = PH_TRAIL; cnt_n = trl_q; end
            else st_n = PH_DONE;
          end
        end else cnt_n = cnt_q - 1'b1;
      end
      PH_TRAIL: if (tick_i) begin
        if (cnt_q == CNT_W'(1)) st_n = PH_DONE;
        else cnt_n = cnt_q - 1'b1;
      end
      default: st_n = PH_IDLE;
    endcase
  end

  assign busy_n = (st_n == PH_LEAD) || (st_n == PH_ACT) || (st_n == PH_TRAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= PH_IDLE;
      cnt_q     <= '0;
      act_q     <= '0;
      trl_q     <= '0;
      hit_q     <= '0;
      wr_q      <= 1'b0;
      ren_q     <= 1'b0;
      cs_n_o    <= '1;
      rd_n_o    <= 1'b1;
      wr_n_o    <= 1'b1;
      data_oe_o <= 1'b0;
      ack_o     <= 1'b0;
      rdata_o   <= '0;
      addr_o    <= '0;
      wdata_o   <= '0;
    end else begin
      st_q      <= st_n;
      cnt_q     <= cnt_n;
      act_q     <= act_n;
      trl_q     <= trl_n;
      hit_q     <= hit_n;
      wr_q      <= wr_n;
      ren_q     <= ren_n;
      cs_n_o    <= busy_n ? ~hit_n : '1;
      rd_n_o    <= !((st_n == PH_ACT) && !wr_n);
      wr_n_o    <= !((st_n == PH_ACT) && wr_n);
      data_oe_o <= busy_n && wr_n;
      ack_o     <= (st_n == PH_DONE);
      if (accept) begin
        addr_o  <= req_addr_i;
        wdata_o <= req_wdata_i;
      end
      if (cap) rdata_o <= rd_data_i;
    end
  end
endmodule

// File: rtl/ebus_ctrl.sv
module ebus_ctrl import ebus_pkg::*; #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int NZ     = 5,
  parameter logic [NZ*ZSEL_W-1:0] ZMAP = {3'd7, 3'd6, 3'd2, 3'd1, 3'd0}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tim_half_i,
  input  logic              clkout_half_i,
  input  logic              clkout_off_i,
  input  logic              cfg_we_i,
  input  logic [ZSEL_W-1:0] cfg_zone_i,
  input  logic [CFG_W-1:0]  cfg_word_i,
  input  logic              req_i,
  input  logic              req_wr_i,
  input  logic [ZSEL_W-1:0] req_zone_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_clk_o,
  output logic [NZ-1:0]     bus_cs_n_o,
  output logic              bus_rd_n_o,
  output logic              bus_wr_n_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_data_oe_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_rdy_i
);
  logic              tick;
  zone_cfg_t [NZ-1:0] zcfg;

  ebus_clkgen #(.REF_W(2)) u_clk (
    .clk       (clk),
    .rst       (rst),
    .tim_half_i(tim_half_i),
    .out_half_i(clkout_half_i),
    .out_off_i (clkout_off_i),
    .tick_o    (tick),
    .clkout_o  (bus_clk_o)
  );

  ebus_zone_regs #(.NZ(NZ), .ZMAP(ZMAP)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we_i  (cfg_we_i),
    .cfg_zone_i(cfg_zone_i),
    .cfg_word_i(zone_cfg_t'(cfg_word_i)),
    .zcfg_o    (zcfg)
  );

  ebus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NZ(NZ), .ZMAP(ZMAP)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick),
    .req_i      (req_i),
    .req_wr_i   (req_wr_i),
    .req_zone_i (req_zone_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .zcfg_i     (zcfg),
    .rdy_i      (bus_rdy_i),
    .rd_data_i  (bus_rdata_i),
    .ack_o      (ack_o),
    .rdata_o    (rdata_o),
    .cs_n_o     (bus_cs_n_o),
    .rd_n_o     (bus_rd_n_o),
    .wr_n_o     (bus_wr_n_o),
    .data_oe_o  (bus_data_oe_o),
    .addr_o     (bus_addr_o),
    .wdata_o    (bus_wdata_o)
  );
endmodule

// File: rtl/ebus_ctrl_chk.sv
module ebus_ctrl_chk #(
  parameter int NZ     = 5,
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              clkout_off_i,
  input logic              ack_o,
  input logic              bus_clk_o,
  input logic [NZ-1:0]     bus_cs_n_o,
  input logic              bus_rd_n_o,
  input logic              bus_wr_n_o,
  input logic              bus_data_oe_o,
  input logic [ADDR_W-1:0] bus_addr_o
);
  // R1
  cs_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_cs_n_o));

  // R4
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd_n_o || !bus_wr_n_o) |-> (bus_cs_n_o != '1));

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_cs_n_o != '1) && ($past(bus_cs_n_o) != '1)) |-> $stable(bus_addr_o));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n_o && !bus_wr_n_o));

  // R7
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    bus_data_oe_o |-> bus_rd_n_o);

  // R11
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);

  // R11
  ack_bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (bus_cs_n_o == '1));

  // R10
  clk_off_low_chk: assert property (@(posedge clk) disable iff (rst)
    clkout_off_i |=> !bus_clk_o);
endmodule

bind ebus_ctrl ebus_ctrl_chk #(.NZ(NZ), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_ebus_ctrl.sv
module tb_ebus_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tim_half_i = 1'b0, clkout_half_i = 1'b0, clkout_off_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_zone_i = '0;
  logic [15:0] cfg_word_i = '0;
  logic        req_i = 1'b0, req_wr_i = 1'b0;
  logic [2:0]  req_zone_i = '0;
  logic [18:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        ack_o, bus_clk_o, bus_rd_n_o, bus_wr_n_o, bus_data_oe_o;
  logic [15:0] rdata_o, bus_wdata_o, bus_rdata_i;
  logic [4:0]  bus_cs_n_o;
  logic [18:0] bus_addr_o;
  logic        bus_rdy_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] model [8];

  always #4 clk = ~clk;

  ebus_ctrl dut (.*);

  function automatic logic [15:0] mem_fn(logic [18:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[18:16], 13'h0};
  endfunction

  assign bus_rdata_i = mem_fn(bus_addr_o);

  function automatic int zidx(int z);
    case (z)
      0: return 0;
      1: return 1;
      2: return 2;
      6: return 3;
      7: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic int fld(logic [15:0] w, int lo, int wd);
    return int'((w >> lo) & ((16'h1 << wd) - 16'h1));
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(int z, logic [15:0] w);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_zone_i = 3'(z); cfg_word_i = w;
    @(negedge clk);
    cfg_we_i = 1'b0;
    if (zidx(z) >= 0) model[z] = w;
  endtask

  // rdy_m = 0: ready stays high; otherwise ready low until rdy_m strobe cycles seen
  task automatic access(int z, bit wr, logic [18:0] a, logic [15:0] d, int rdy_m);
    int idx = zidx(z);
    logic [15:0] w = model[z];
    int base = wr ? 7 : 0;
    int tp = tim_half_i ? 4 : 2;
    int dbl = int'(w[15]);
    int lc = fld(w, base, 2) << dbl;
    int ac = (fld(w, base + 2, 3) == 0 ? 1 : fld(w, base + 2, 3)) << dbl;
    int tc = fld(w, base + 5, 2) << dbl;
    int k = ac;
    int csc = 0, stbc = 0, leadc = 0, bad = 0, guard = 0;
    bit seen = 0, prev_cs = 0, ack_after_cs = 0, stb, oth, cs_low;
    if (w[14] && rdy_m > 0 && ((rdy_m + tp - 1) / tp) > k) k = (rdy_m + tp - 1) / tp;
    @(negedge clk);
    req_i = 1'b1; req_wr_i = wr; req_zone_i = 3'(z); req_addr_i = a; req_wdata_i = d;
    bus_rdy_i = (rdy_m == 0);
    forever begin
      @(negedge clk);
      cs_low = (bus_cs_n_o != 5'h1F);
      stb = wr ? !bus_wr_n_o : !bus_rd_n_o;
      oth = wr ? !bus_rd_n_o : !bus_wr_n_o;
      if (cs_low) begin
        csc++;
        if (idx < 0 || bus_cs_n_o != ~(5'b1 << idx)) bad++;
        if (bus_addr_o != a) bad++;
        if (bus_data_oe_o != wr) bad++;
        if (wr && bus_wdata_o != d) bad++;
      end
      if (oth || (stb && !cs_low)) bad++;
      if (stb) begin
        stbc++; seen = 1;
        if (rdy_m != 0 && stbc >= rdy_m) bus_rdy_i = 1'b1;
      end else if (cs_low && !seen) leadc++;
      if (ack_o) begin ack_after_cs = prev_cs && !cs_low; break; end
      prev_cs = cs_low;
      guard++;
      if (guard > 2000) break;
    end
    req_i = 1'b0; bus_rdy_i = 1'b1;
    check("R11 transfer completes", int'(guard <= 2000), 1);
    if (idx < 0) begin
      check("R2 no chip select on unmapped zone", csc, 0);
      check("R2 no strobe on unmapped zone", stbc, 0);
    end else begin
      check("R1 R7 zone, address and data violations", bad, 0);
      check("R4 R9 setup length", leadc, lc * tp);
      check("R4 R5 R8 strobe length", stbc, k * tp);
      check("R4 R5 R9 chip-select window", csc, (lc + k + tc) * tp);
      check("R11 ack right after hold", int'(ack_after_cs), 1);
      if (!wr) check("R6 read data", int'(rdata_o), int'(mem_fn(a)));
    end
    @(negedge clk);
    check("R11 single ack", int'(ack_o), 0);
  endtask

  task automatic clk_check(bit th, bit oh, bit off, int h);
    int tr = 0;
    logic prev;
    @(negedge clk);
    tim_half_i = th; clkout_half_i = oh; clkout_off_i = off;
    repeat (4) @(negedge clk);
    prev = bus_clk_o;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (bus_clk_o != prev) tr++;
      prev = bus_clk_o;
    end
    check("R10 bus clock transitions", tr, off ? 0 : 16 / h);
    if (off) check("R10 bus clock held low", int'(bus_clk_o), 0);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd4242);
    for (int i = 0; i < 8; i++) model[i] = 16'h3FFF;
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 chip-selects high", int'(bus_cs_n_o), 31);
    check("R13 strobes high", int'({bus_rd_n_o, bus_wr_n_o}), 3);
    check("R13 drive, ack and clock low", int'({bus_data_oe_o, ack_o, bus_clk_o}), 0);
    check("R13 read data cleared", int'(rdata_o), 0);
    @(negedge clk); rst = 1'b0;

    // R3 reset timing word, R9 both timing rates
    access(0, 0, 19'h12345, 16'h0, 0);
    tim_half_i = 1'b1;
    access(7, 1, 19'h7ABCD, 16'hBEEF, 0);
    tim_half_i = 1'b0;

    // R10 bus clock modes
    clk_check(0, 0, 0, 1);
    clk_check(0, 1, 0, 2);
    clk_check(1, 0, 0, 2);
    clk_check(1, 1, 0, 4);
    clk_check(1, 1, 1, 1);
    clk_check(0, 0, 0, 1);

    // R3 strobe count 0 acts as 1, no setup or hold
    cfg_write(1, 16'h0000);
    access(1, 0, 19'h00042, 16'h0, 0);
    access(1, 1, 19'h00043, 16'h1234, 0);
    // R5 doubling with strobe 7
    cfg_write(2, 16'h8000 | 16'h001C | (16'd1 << 7) | (16'd7 << 9));
    access(2, 0, 19'h2F0F0, 16'h0, 0);
    access(2, 1, 19'h2F0F1, 16'hA5A5, 0);
    // R8 ready stretch enabled, and ignored when disabled
    cfg_write(6, 16'h4000 | (16'd2 << 2) | 16'd1 | (16'd1 << 5));
    access(6, 0, 19'h60001, 16'h0, 7);
    tim_half_i = 1'b1;
    access(6, 0, 19'h60002, 16'h0, 13);
    tim_half_i = 1'b0;
    cfg_write(6, (16'd2 << 2) | 16'd1 | (16'd1 << 5));
    access(6, 0, 19'h60003, 16'h0, 9);
    // R2 unmapped zones
    access(3, 0, 19'h11111, 16'h0, 0);
    access(4, 1, 19'h22222, 16'h7777, 0);
    access(5, 0, 19'h33333, 16'h0, 0);
    // R12 write to unmapped zone leaves mapped zones unchanged
    cfg_write(5, 16'h0000);
    cfg_write(4, 16'h8000);
    access(6, 1, 19'h61234, 16'h4321, 0);
    access(7, 0, 19'h71234, 16'h0, 0);
    // R12 timing write in the middle of a transfer
    cfg_write(0, 16'h3FFF);
    fork
      access(0, 0, 19'h05555, 16'h0, 0);
      begin
        repeat (8) @(negedge clk);
        cfg_write(0, 16'h0000);
      end
    join
    access(0, 0, 19'h05556, 16'h0, 0);

    // random traffic
    for (int it = 0; it < 60; it++) begin
      int z = int'($urandom_range(7, 0));
      if ($urandom_range(2, 0) == 0)
        cfg_write(int'($urandom_range(7, 0)), 16'($urandom()));
      tim_half_i = 1'($urandom_range(1, 0));
      clkout_half_i = 1'($urandom_range(1, 0));
      access(z, 1'($urandom_range(1, 0)), 19'($urandom()), 16'($urandom()),
             ($urandom_range(3, 0) == 0) ? int'($urandom_range(20, 1)) : 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule